// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel samples. It takes a bit clock, a frame clock and one data line, oversamples all three on the system clock, and rebuilds a 24-bit signed left sample and a 24-bit signed right sample for each stereo frame. When a complete left/right pair has been received, it raises `pair_valid` for one cycle.

Two configuration inputs select the framing and the word length. The framing can be I2S, left-justified, right-justified or a DSP-style pulse framing. The word length can be 16, 18, 20 or 24 bits. Words shorter than 24 bits are placed at the top of the output and padded with zeros. Both configuration inputs reset to zero, which selects 24-bit I2S.

The frame logic is a three-state machine:
- SEEK: after reset, waiting for the first left half-frame.
- LEFT: a left word is being gathered.
- RIGHT: a right word is being gathered.

A half-frame start that names the left channel is called LEFT_START. The transitions are:
- SEEK to LEFT on LEFT_START.
- LEFT to RIGHT on a right start. This stores the left word.
- RIGHT to LEFT on LEFT_START. This publishes the pair.
- LEFT to LEFT on LEFT_START. The partial left word is dropped.
- RIGHT to RIGHT on a repeated right start.

In SEEK, right starts are ignored.

Top module: `audio_rx_top`

## Requirements
- R1: While reset is held and until the first pair is published, `left_out` and `right_out` read zero and `pair_valid` is low. The reset configuration {`fmt_sel`=00, `wlen_sel`=00} selects 24-bit I2S.
- R2: `fmt_sel`=00 (I2S). Bits are sampled on the rising bit-clock edge. Frame low marks left and frame high marks right. The MSB arrives one bit clock after the frame transition.
- R3: `fmt_sel`=11 (left-justified). Bits are sampled on the rising edge. Frame high marks left and frame low marks right. The MSB is the bit at the frame transition.
- R4: `fmt_sel`=01 (right-justified). Frame high marks left. Half-frame positions are counted from 0 at the transition bit. Capture runs from position 8, 12, 14 or 16 through position 31, for `wlen_sel` 00=24, 01=20, 10=18 and 11=16 bits. Bits before the window are ignored.
- R5: `fmt_sel`=10 (DSP). Bits are sampled on the falling edge. The first low bit after a high frame pulse is the MSB of a new word. Bits sampled while the frame is high are ignored. The first pulse after reset is left, and the channels alternate from then on.
- R6: In I2S, left-justified and DSP modes, any number of bits is accepted. Bits past the 24th of a word are dropped.
- R7: A word shorter than 24 bits appears MSB-aligned in the output, with the unused low bits zero.
- R8: Left-justified mode also works with a packed frame of 16 bit clocks per half-frame.
- R9: `pair_valid` is a one-cycle pulse, once per received pair, issued when the next left half-frame begins. `left_out` and `right_out` change only in that cycle.
- R10: The left word always precedes the right word. A right word received after reset with no left word before it is never published.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_in | input | 1 | Serial bit clock |
| fsync_in | input | 1 | Frame (channel) clock |
| sdata_in | input | 1 | Serial data, MSB first, two's complement |
| fmt_sel | input | 2 | Framing: 00 I2S, 01 right-justified, 10 DSP, 11 left-justified |
| wlen_sel | input | 2 | Right-justified word length: 00 24, 01 20, 10 18, 11 16 bits |
| left_out | output | 24 | Last published left sample |
| right_out | output | 24 | Last published right sample |
| pair_valid | output | 1 | One-cycle strobe when a new pair is published |

## Verification
The embedded properties check these rules on every cycle:
- The strobe lasts exactly one cycle.
- The outputs hold between strobes.
- Every strobe follows the RIGHT state.
- The word counter never passes 24.
- The zero padding of a 16-bit right-justified sample.

Only the bench scenarios can show the following:
- The channel polarity of each format.
- The one-bit MSB delay in I2S.
- The position of the right-justified window.
- Falling-edge sampling in DSP mode.
- Truncation past 24 bits.
- Packed frames.
- The rule that a lone right word after reset is never published.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_RJ  = 2'b01,
        FMT_DSP = 2'b10,
        FMT_LJ  = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_SEEK  = 2'b00,
        ST_LEFT  = 2'b01,
        ST_RIGHT = 2'b10
    } rx_state_e;

    // Bits carried by a right-justified word for each length code.
    function automatic int unsigned wlen_bits(input logic [1:0] code);
        unique case (code)
            2'b00:   return 24;
            2'b01:   return 20;
            2'b10:   return 18;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/audio_rx_edge.sv
module audio_rx_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic fsync_in,
    input  logic sdata_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic fsync_s,
    output logic sdata_s
);
    // All three lines pass through the same number of stages, so they stay aligned.
    logic [SYNC_STAGES-1:0] sclk_sh;
    logic [SYNC_STAGES-1:0] fsync_sh;
    logic [SYNC_STAGES-1:0] sdata_sh;
    logic                   sclk_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sh  <= '0;
            fsync_sh <= '0;
            sdata_sh <= '0;
            sclk_d   <= 1'b0;
        end else begin
            sclk_sh  <= {sclk_sh[SYNC_STAGES-2:0],  sclk_in};
            fsync_sh <= {fsync_sh[SYNC_STAGES-2:0], fsync_in};
            sdata_sh <= {sdata_sh[SYNC_STAGES-2:0], sdata_in};
            sclk_d   <= sclk_sh[SYNC_STAGES-1];
        end
    end

    assign sclk_rise = sclk_sh[SYNC_STAGES-1] & ~sclk_d;
    assign sclk_fall = ~sclk_sh[SYNC_STAGES-1] & sclk_d;
    assign fsync_s   = fsync_sh[SYNC_STAGES-1];
    assign sdata_s   = sdata_sh[SYNC_STAGES-1];

endmodule

// File: rtl/audio_rx_slot.sv
module audio_rx_slot
    import audio_rx_pkg::*;
#(
    parameter int HALF_BITS = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] fmt_sel,
    input  logic [1:0] wlen_sel,
    input  logic       fsync_s,
    input  logic       in_left,
    output logic       half_start,
    output logic       start_left,
    output logic       cap_en
);
    localparam int POS_W = $clog2(HALF_BITS + 1);

    logic             fs_p1;
    logic             fs_p2;
    logic [1:0]       hist_q;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_cur;
    logic [POS_W-1:0] rj_first;
    logic             in_window;

    // Decide whether this bit opens a half-frame, and which channel it opens.
    always_comb begin
        half_start = 1'b0;
        start_left = 1'b0;
        unique case (fmt_e'(fmt_sel))
            FMT_LJ, FMT_RJ: begin
                half_start = (hist_q != 2'd0) && (fsync_s != fs_p1);
                start_left = fsync_s;
            end
            FMT_I2S: begin
                // The frame level seen one bit earlier marks the channel.
                half_start = (hist_q == 2'd2) && (fs_p1 != fs_p2);
                start_left = ~fs_p1;
            end
            FMT_DSP: begin
                half_start = (hist_q != 2'd0) && fs_p1 && !fsync_s;
                start_left = ~in_left;
            end
            default: begin
                half_start = 1'b0;
                start_left = 1'b0;
            end
        endcase
    end

    assign pos_cur   = half_start ? '0 : pos_q;
    assign rj_first  = POS_W'(HALF_BITS) - POS_W'(wlen_bits(wlen_sel));
    assign in_window = (pos_cur >= rj_first) && (pos_cur < POS_W'(HALF_BITS));

    // Decide whether this bit is captured into the current word.
    always_comb begin
        unique case (fmt_e'(fmt_sel))
            FMT_RJ:  cap_en = in_window;
            FMT_DSP: cap_en = ~fsync_s;
            default: cap_en = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_p1  <= 1'b0;
            fs_p2  <= 1'b0;
            hist_q <= 2'd0;
            pos_q  <= '0;
        end else if (tick) begin
            fs_p1 <= fsync_s;
            fs_p2 <= fs_p1;
            if (hist_q != 2'd2) begin
                hist_q <= hist_q + 2'd1;
            end
            if (pos_cur != POS_W'(HALF_BITS)) begin
                pos_q <= pos_cur + 1'b1;
            end else begin
                pos_q <= pos_cur;
            end
        end
    end

endmodule

// File: rtl/audio_rx_word.sv
module audio_rx_word #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         restart,
    input  logic         cap_en,
    input  logic         bit_in,
    output logic [W-1:0] word_o
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     sr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] shamt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            if (restart) begin
                sr_q  <= cap_en ? {{(W-1){1'b0}}, bit_in} : '0;
                cnt_q <= cap_en ? CNT_W'(1) : '0;
            end else if (cap_en && (cnt_q < CNT_W'(W))) begin
                sr_q  <= {sr_q[W-2:0], bit_in};
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Shift the captured bits up to the MSB end; the free low bits read zero.
    assign shamt  = CNT_W'(W) - cnt_q;
    assign word_o = sr_q << shamt;

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(W));

endmodule

// File: rtl/audio_rx_top.sv
module audio_rx_top
    import audio_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SAMPLE_W    = 24,
    parameter int HALF_BITS   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_in,
    input  logic                fsync_in,
    input  logic                sdata_in,
    input  logic [1:0]          fmt_sel,
    input  logic [1:0]          wlen_sel,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                pair_valid
);
    localparam int PAD_HI = SAMPLE_W - 17;

    logic                sclk_rise;
    logic                sclk_fall;
    logic                fsync_s;
    logic                sdata_s;
    logic                tick;
    logic                half_start;
    logic                start_left;
    logic                cap_en;
    logic                open_evt;
    logic [SAMPLE_W-1:0] word;
    logic [SAMPLE_W-1:0] left_hold;
    rx_state_e           state_q;
    rx_state_e           state_d;

    audio_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (sclk_in),
        .fsync_in  (fsync_in),
        .sdata_in  (sdata_in),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .fsync_s   (fsync_s),
        .sdata_s   (sdata_s)
    );

    // DSP framing samples on the falling edge; the other formats sample on the rising edge.
    assign tick = (fmt_e'(fmt_sel) == FMT_DSP) ? sclk_fall : sclk_rise;

    audio_rx_slot #(.HALF_BITS(HALF_BITS)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .fmt_sel    (fmt_sel),
        .wlen_sel   (wlen_sel),
        .fsync_s    (fsync_s),
        .in_left    (state_q == ST_LEFT),
        .half_start (half_start),
        .start_left (start_left),
        .cap_en     (cap_en)
    );

    audio_rx_word #(.W(SAMPLE_W)) u_word (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (half_start),
        .cap_en  (cap_en),
        .bit_in  (sdata_s),
        .word_o  (word)
    );

    assign open_evt = tick && half_start;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEEK;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (open_evt) begin
            unique case (state_q)
                ST_SEEK:  state_d = start_left ? ST_LEFT : ST_SEEK;
                ST_LEFT:  state_d = start_left ? ST_LEFT : ST_RIGHT;
                ST_RIGHT: state_d = start_left ? ST_LEFT : ST_RIGHT;
                default:  state_d = ST_SEEK;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_hold  <= '0;
            left_out   <= '0;
            right_out  <= '0;
            pair_valid <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            if (open_evt) begin
                unique case (state_q)
                    ST_LEFT: begin
                        if (!start_left) begin
                            left_hold <= word;
                        end
                    end
                    ST_RIGHT: begin
                        if (start_left) begin
                            left_out   <= left_hold;
                            right_out  <= word;
                            pair_valid <= 1'b1;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // R9
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    // R9
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> ($stable(left_out) && $stable(right_out)));

    // R10
    valid_after_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> ($past(state_q) == ST_RIGHT));

    // R7
    rj16_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && (fmt_sel == 2'b01) && (wlen_sel == 2'b11))
            |-> (right_out[PAD_HI:0] == '0));

endmodule

// File: tb/sim_audio_rx_top.sv
module sim_audio_rx_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        fs = 1'b0;
    logic        sd = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic [1:0]  wlen = 2'b00;
    logic [23:0] left_out;
    logic [23:0] right_out;
    logic        pair_valid;

    int          nchk = 0;
    int          nfail = 0;
    int          nvalid = 0;
    logic [23:0] lat_l = '0;
    logic [23:0] lat_r = '0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    audio_rx_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_in    (sclk),
        .fsync_in   (fs),
        .sdata_in   (sd),
        .fmt_sel    (fmt),
        .wlen_sel   (wlen),
        .left_out   (left_out),
        .right_out  (right_out),
        .pair_valid (pair_valid)
    );

    // Record each published pair, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && pair_valid) begin
            nvalid++;
            lat_l = left_out;
            lat_r = right_out;
        end
    end

    // Stimulus fields: fmt | wlen | bits sent | bits per half | left | right
    localparam int NVEC = 14;
    localparam logic [63:0] VEC [NVEC] = '{
        {2'b00, 2'b00, 6'd24, 6'd32, 24'h123456, 24'hFEDCBA},
        {2'b00, 2'b00, 6'd16, 6'd32, 24'hA5C3F1, 24'h3C5A77},
        {2'b00, 2'b00, 6'd28, 6'd32, 24'h0F0F0F, 24'h800001},
        {2'b11, 2'b00, 6'd24, 6'd32, 24'h654321, 24'h89ABCD},
        {2'b11, 2'b00, 6'd20, 6'd32, 24'h13579B, 24'h2468AC},
        {2'b11, 2'b00, 6'd30, 6'd32, 24'hC0FFEE, 24'h00BEEF},
        {2'b11, 2'b00, 6'd16, 6'd16, 24'hDEAD55, 24'hBEEF33},
        {2'b01, 2'b00, 6'd0,  6'd32, 24'hABCDEF, 24'h123457},
        {2'b01, 2'b01, 6'd0,  6'd32, 24'hABCDEF, 24'h123457},
        {2'b01, 2'b10, 6'd0,  6'd32, 24'hABCDEF, 24'h123457},
        {2'b01, 2'b11, 6'd0,  6'd32, 24'hABCDEF, 24'h123457},
        {2'b10, 2'b00, 6'd24, 6'd32, 24'h7E8199, 24'h1F2E3D},
        {2'b10, 2'b00, 6'd18, 6'd32, 24'h7E8199, 24'h1F2E3D},
        {2'b10, 2'b00, 6'd26, 6'd32, 24'h4B3C2D, 24'h90817F}
    };

    function automatic string vec_tag(input int k);
        case (k)
            0:       return "R1 R2";
            1:       return "R2 R7";
            2:       return "R2 R6";
            3:       return "R3";
            4:       return "R3 R7";
            5:       return "R3 R6";
            6:       return "R8";
            7, 9:    return "R4";
            8, 10:   return "R4 R7";
            11:      return "R5";
            12:      return "R5 R7";
            default: return "R5 R6";
        endcase
    endfunction

    function automatic int rj_bits(input logic [1:0] c);
        case (c)
            2'b00:   return 24;
            2'b01:   return 20;
            2'b10:   return 18;
            default: return 16;
        endcase
    endfunction

    // Bit i of a sent word: ones past the 24th bit, zeros past the sent length.
    function automatic logic src_bit(input logic [23:0] v, input int i, input int nb);
        if (i < 0 || i >= nb) return 1'b0;
        if (i >= 24) return 1'b1;
        return v[23-i];
    endfunction

    function automatic logic [23:0] top_bits(input logic [23:0] v, input int n);
        logic [23:0] m;
        m = 24'hFFFFFF << (24 - n);
        return v & m;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bit_cycle(input logic f, input logic d, input bit dsp);
        @(negedge clk);
        sclk = dsp;
        fs   = f;
        sd   = d;
        repeat (4) @(negedge clk);
        sclk = ~dsp;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_half(input logic [1:0] fm, input logic [1:0] wl, input int nb,
                             input int hl, input bit ch, input logic [23:0] val);
        for (int p = 0; p < hl; p++) begin
            logic f;
            logic d;
            int   first;
            case (fm)
                2'b11: begin f = ~ch; d = src_bit(val, p, nb); end
                2'b00: begin f = ch; d = (p == 0) ? 1'b0 : src_bit(val, p - 1, nb); end
                2'b10: begin f = (p == 0); d = (p == 0) ? 1'b1 : src_bit(val, p - 1, nb); end
                default: begin
                    first = hl - rj_bits(wl);
                    f = ~ch;
                    d = (p < first) ? 1'b1 : val[23-(p-first)];
                end
            endcase
            bit_cycle(f, d, fm == 2'b10);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sclk  = 1'b0;
        fs    = 1'b0;
        sd    = 1'b0;
        repeat (4) @(negedge clk);
        nvalid = 0;
        lat_l  = '0;
        lat_r  = '0;
        rst_n  = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_vec(input int k);
        logic [1:0]  fm;
        logic [1:0]  wl;
        int          nb;
        int          hl;
        int          n;
        logic [23:0] lv;
        logic [23:0] rv;
        fm = VEC[k][63:62];
        wl = VEC[k][61:60];
        nb = int'(VEC[k][59:54]);
        hl = int'(VEC[k][53:48]);
        lv = VEC[k][47:24];
        rv = VEC[k][23:0];
        fmt  = fm;
        wlen = wl;
        do_reset();
        // Idle bits at the level that does not open a left half-frame.
        for (int i = 0; i < 2; i++) begin
            bit_cycle((fm == 2'b00), 1'b0, fm == 2'b10);
        end
        for (int fr = 0; fr < 4; fr++) begin
            send_half(fm, wl, nb, hl, 1'b0, lv);
            send_half(fm, wl, nb, hl, 1'b1, rv);
        end
        repeat (12) @(negedge clk);
        n = (fm == 2'b01) ? rj_bits(wl) : ((nb > 24) ? 24 : nb);
        chk({vec_tag(k), " R9 pair count"}, nvalid, 3);
        chk({vec_tag(k), " left"},  {8'h0, lat_l}, {8'h0, top_bits(lv, n)});
        chk({vec_tag(k), " right"}, {8'h0, lat_r}, {8'h0, top_bits(rv, n)});
    endtask

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 left_out", {8'h0, left_out}, 32'h0);
        chk("R1 right_out", {8'h0, right_out}, 32'h0);
        chk("R1 pair_valid", {31'h0, pair_valid}, 32'h0);

        for (int k = 0; k < NVEC; k++) begin
            run_vec(k);
        end

        // R10: a lone right word after reset is never published
        fmt  = 2'b11;
        wlen = 2'b00;
        do_reset();
        bit_cycle(1'b1, 1'b0, 1'b0);
        bit_cycle(1'b1, 1'b0, 1'b0);
        send_half(2'b11, 2'b00, 24, 32, 1'b1, 24'h777777);
        chk("R10 no publish before left", nvalid, 0);
        send_half(2'b11, 2'b00, 24, 32, 1'b0, 24'h111111);
        send_half(2'b11, 2'b00, 24, 32, 1'b1, 24'h222222);
        send_half(2'b11, 2'b00, 24, 32, 1'b0, 24'h000000);
        repeat (12) @(negedge clk);
        chk("R10 pair count", nvalid, 1);
        chk("R10 left", {8'h0, lat_l}, 32'h00111111);
        chk("R10 right", {8'h0, lat_r}, 32'h00222222);
        // R9: strobe has returned low and the outputs hold
        chk("R9 strobe low", {31'h0, pair_valid}, 32'h0);
        chk("R9 right holds", {8'h0, right_out}, 32'h00222222);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule